// File: doc/BRIEF.md
# Self-Timed Page Operation Sequencer

This block runs the internal work that follows the end of a serial command: once the command interface raises a one-cycle start pulse together with an opcode and a page number, the sequencer carries out a whole page operation on its own and holds a busy flag until it has finished. It owns a small main-memory array, organised as pages of bytes, and a one-page data buffer. Serial shifting and the physics of the flash cells are outside the block. Buffer filling and memory reads are plain synchronous ports.

Two operations are supported. Buffered page program (opcode 0x82) erases the selected page to all ones and then copies the buffer into it. Auto page rewrite (opcode 0x58) first copies the selected page into the buffer and then runs the same erase and program sequence, so the page ends up refreshed with its own contents. The erase and program phases are timed by a cycle counter. Each phase lasts a programmable number of clock cycles, capped at a maximum operation time. A phase never ends before all of its byte accesses are done.

Top module: `pageop_sequencer`

## Requirements
- R1: While reset is held and in the cycle after it is released, busy is 0. An unrecognized opcode does not start anything.
- R2: A start pulse seen while idle with opcode 0x82 raises busy in the next cycle. The sequence is an erase phase, then a program phase, then a one-cycle done state.
- R3: During the erase phase, every byte of the selected page reads 0xFF on the array read port, and the erase phase lasts at least ERASE_CYC cycles (capped at T_MAX).
- R4: After a program, every byte of the selected page equals the buffer byte at the same index, and no other page changes.
- R5: A start with opcode 0x58 copies the selected page into the buffer, then erases and programs that page back. Afterwards both the page and the buffer hold the page's former contents.
- R6: Busy stays 1 for the whole operation and falls when the sequencer returns to idle. A program keeps busy high for ERASE_LEN+PROG_LEN+1 cycles, and a rewrite adds PAGE_BYTES+2 transfer cycles.
- R7: A start pulse received while busy is ignored. The running operation keeps its page and its length, and the page named by the ignored request is not touched.
- R8: A start pulse with any opcode other than 0x82 or 0x58 leaves busy at 0 and changes no memory.
- R9: Host writes to the buffer are ignored while busy is 1.
- R10: The array read port returns the byte at arr_raddr (page*PAGE_BYTES+byte) one cycle after the address, including while an operation runs. The buffer read port likewise returns its byte one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request from the command interface |
| opcode | input | 8 | Operation code sampled with start |
| page | input | $clog2(NUM_PAGES) | Page selected by the request |
| busy | output | 1 | High while an operation runs |
| hbuf_we | input | 1 | Host buffer write enable (ignored while busy) |
| hbuf_addr | input | $clog2(PAGE_BYTES) | Host buffer write byte index |
| hbuf_wdata | input | 8 | Host buffer write data |
| hbuf_raddr | input | $clog2(PAGE_BYTES) | Host buffer read byte index |
| hbuf_rdata | output | 8 | Buffer read data, one cycle latency |
| arr_raddr | input | $clog2(NUM_PAGES*PAGE_BYTES) | Array read address |
| arr_rdata | output | 8 | Array read data, one cycle latency |

## Verification
On every cycle, the assertions check that busy matches a non-idle state, that only erase or program writes the array, that erase writes only 0xFF, that phases follow the order transfer, erase, program, done, that the erase phase does not end early, and that the latched page stays fixed while busy. The bench's scenarios alone show the data results: that a program leaves the buffer's random contents in the page and leaves the other pages alone, that a rewrite restores the page and fills the buffer, that the page reads as 0xFF in the middle of an erase, and that ignored requests and host writes really have no effect on memory or on the busy length.

// File: rtl/pageop_pkg.sv
package pageop_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_XFER  = 3'd1,
    ST_ERASE = 3'd2,
    ST_PROG  = 3'd3,
    ST_DONE  = 3'd4
  } seq_state_e;

  localparam logic [7:0] OP_PAGE_PROG = 8'h82;
  localparam logic [7:0] OP_REWRITE   = 8'h58;
  localparam logic [7:0] ERASED_BYTE  = 8'hFF;
endpackage

// File: rtl/pageop_ram.sv
// Memory with one write port and NRD registered read ports. It is coded so
// that block RAM can be inferred.
module pageop_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 264,
  parameter int NRD   = 1,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [DW-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0][DW-1:0]  rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NRD; i++) rdata[i] <= mem[raddr[i]];
  end
endmodule

// File: rtl/pageop_ctrl.sv
// Sequencer state machine, byte index and phase timer.
module pageop_ctrl
  import pageop_pkg::*;
#(
  parameter int PAGE_BYTES = 264,
  parameter int PAW        = 3,
  parameter int ERASE_LEN  = 300,
  parameter int PROG_LEN   = 320,
  parameter int TW         = 10,
  parameter int BW         = $clog2(PAGE_BYTES + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [7:0]      opcode,
  input  logic [PAW-1:0]  page,
  output logic            busy,
  output seq_state_e      st,
  output logic [PAW-1:0]  pg_q,
  output logic [BW-1:0]   idx,
  output logic            rd_go,
  output logic            buf_we_int,
  output logic [BW-1:0]   buf_widx,
  output logic            arr_we,
  output logic [BW-1:0]   arr_widx,
  output logic            arr_fill
);
  localparam logic [BW-1:0] LAST   = BW'(PAGE_BYTES);
  localparam logic [TW-1:0] E_END  = TW'(ERASE_LEN - 1);
  localparam logic [TW-1:0] P_END  = TW'(PROG_LEN - 1);

  logic          wv;
  logic [BW-1:0] widx;
  logic [TW-1:0] tmr;
  logic          idx_done;
  logic          req_ok;

  assign idx_done   = (idx == LAST);
  assign req_ok     = start && ((opcode == OP_PAGE_PROG) || (opcode == OP_REWRITE));
  assign rd_go      = ((st == ST_XFER) || (st == ST_PROG)) && !idx_done;
  assign buf_we_int = (st == ST_XFER) && wv;
  assign buf_widx   = widx;
  assign arr_fill   = (st == ST_ERASE);
  assign arr_we     = ((st == ST_ERASE) && !idx_done) || ((st == ST_PROG) && wv);
  assign arr_widx   = (st == ST_ERASE) ? idx : widx;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      busy <= 1'b0;
      pg_q <= '0;
      idx  <= '0;
      widx <= '0;
      wv   <= 1'b0;
      tmr  <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (req_ok) begin
            pg_q <= page;
            st   <= (opcode == OP_REWRITE) ? ST_XFER : ST_ERASE;
            busy <= 1'b1;
            idx  <= '0;
            tmr  <= '0;
            wv   <= 1'b0;
          end
        end
        ST_XFER: begin
          wv   <= rd_go;
          widx <= idx;
          if (rd_go) idx <= idx + 1'b1;
          if (idx_done && !wv) begin
            st  <= ST_ERASE;
            idx <= '0;
            tmr <= '0;
          end
        end
        ST_ERASE: begin
          tmr <= tmr + 1'b1;
          if (!idx_done) idx <= idx + 1'b1;
          if (idx_done && (tmr >= E_END)) begin
            st  <= ST_PROG;
            idx <= '0;
            tmr <= '0;
            wv  <= 1'b0;
          end
        end
        ST_PROG: begin
          tmr  <= tmr + 1'b1;
          wv   <= rd_go;
          widx <= idx;
          if (rd_go) idx <= idx + 1'b1;
          if (idx_done && !wv && (tmr >= P_END)) st <= ST_DONE;
        end
        ST_DONE: begin
          st   <= ST_IDLE;
          busy <= 1'b0;
        end
        default: begin
          st   <= ST_IDLE;
          busy <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/pageop_sequencer.sv
// Top: sequencer, main-memory array and page buffer.
module pageop_sequencer
  import pageop_pkg::*;
#(
  parameter int NUM_PAGES  = 8,
  parameter int PAGE_BYTES = 264,
  parameter int ERASE_CYC  = 300,
  parameter int PROG_CYC   = 320,
  parameter int T_MAX      = 1000
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   start,
  input  logic [7:0]                             opcode,
  input  logic [$clog2(NUM_PAGES)-1:0]           page,
  output logic                                   busy,
  input  logic                                   hbuf_we,
  input  logic [$clog2(PAGE_BYTES)-1:0]          hbuf_addr,
  input  logic [7:0]                             hbuf_wdata,
  input  logic [$clog2(PAGE_BYTES)-1:0]          hbuf_raddr,
  output logic [7:0]                             hbuf_rdata,
  input  logic [$clog2(NUM_PAGES*PAGE_BYTES)-1:0] arr_raddr,
  output logic [7:0]                             arr_rdata
);
  localparam int PAW       = $clog2(NUM_PAGES);
  localparam int BAW       = $clog2(PAGE_BYTES);
  localparam int AAW       = $clog2(NUM_PAGES * PAGE_BYTES);
  localparam int BW        = $clog2(PAGE_BYTES + 1);
  localparam int ERASE_LEN = (ERASE_CYC < 1) ? 1 : ((ERASE_CYC > T_MAX) ? T_MAX : ERASE_CYC);
  localparam int PROG_LEN  = (PROG_CYC < 1) ? 1 : ((PROG_CYC > T_MAX) ? T_MAX : PROG_CYC);
  localparam int T_TOP     = (T_MAX > PAGE_BYTES) ? T_MAX : PAGE_BYTES;
  localparam int TW        = $clog2(T_TOP + 4);
  localparam logic [AAW-1:0] PB_A = AAW'(PAGE_BYTES);

  seq_state_e      st;
  logic [PAW-1:0]  pg_q;
  logic [BW-1:0]   idx;
  logic            rd_go;
  logic            buf_we_int;
  logic [BW-1:0]   buf_widx;
  logic            arr_we;
  logic [BW-1:0]   arr_widx;
  logic            arr_fill;
  logic [AAW-1:0]  page_base;

  logic [AAW-1:0]          arr_waddr;
  logic [7:0]              arr_wdata;
  logic [1:0][AAW-1:0]     arr_rd_addr;
  logic [1:0][7:0]         arr_rd_data;

  logic                    buf_we;
  logic [BAW-1:0]          buf_waddr;
  logic [7:0]              buf_wdata;
  logic [0:0][BAW-1:0]     buf_rd_addr;
  logic [0:0][7:0]         buf_rd_data;

  logic [15:0]             erase_len_w;

  pageop_ctrl #(
    .PAGE_BYTES (PAGE_BYTES),
    .PAW        (PAW),
    .ERASE_LEN  (ERASE_LEN),
    .PROG_LEN   (PROG_LEN),
    .TW         (TW),
    .BW         (BW)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .opcode     (opcode),
    .page       (page),
    .busy       (busy),
    .st         (st),
    .pg_q       (pg_q),
    .idx        (idx),
    .rd_go      (rd_go),
    .buf_we_int (buf_we_int),
    .buf_widx   (buf_widx),
    .arr_we     (arr_we),
    .arr_widx   (arr_widx),
    .arr_fill   (arr_fill)
  );

  assign page_base   = AAW'(pg_q) * PB_A;
  assign erase_len_w = 16'(ERASE_LEN);

  // Array: port 0 serves the page-to-buffer transfer, port 1 the host.
  assign arr_waddr      = page_base + AAW'(arr_widx);
  assign arr_wdata      = arr_fill ? ERASED_BYTE : buf_rd_data[0];
  assign arr_rd_addr[0] = page_base + AAW'(idx);
  assign arr_rd_addr[1] = arr_raddr;
  assign arr_rdata      = arr_rd_data[1];

  pageop_ram #(
    .DW    (8),
    .DEPTH (NUM_PAGES * PAGE_BYTES),
    .NRD   (2),
    .AW    (AAW)
  ) u_array (
    .clk   (clk),
    .we    (arr_we),
    .waddr (arr_waddr),
    .wdata (arr_wdata),
    .raddr (arr_rd_addr),
    .rdata (arr_rd_data)
  );

  // Buffer: the sequencer owns both ports while busy.
  always_comb begin
    if (busy) begin
      buf_we         = buf_we_int;
      buf_waddr      = BAW'(buf_widx);
      buf_wdata      = arr_rd_data[0];
      buf_rd_addr[0] = BAW'(idx);
    end else begin
      buf_we         = hbuf_we;
      buf_waddr      = hbuf_addr;
      buf_wdata      = hbuf_wdata;
      buf_rd_addr[0] = hbuf_raddr;
    end
  end

  assign hbuf_rdata = buf_rd_data[0];

  pageop_ram #(
    .DW    (8),
    .DEPTH (PAGE_BYTES),
    .NRD   (1),
    .AW    (BAW)
  ) u_buffer (
    .clk   (clk),
    .we    (buf_we),
    .waddr (buf_waddr),
    .wdata (buf_wdata),
    .raddr (buf_rd_addr),
    .rdata (buf_rd_data)
  );
endmodule

// File: rtl/pageop_seq_chk.sv
module pageop_seq_chk
  import pageop_pkg::*;
#(
  parameter int PAW = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           busy,
  input seq_state_e     st,
  input logic [PAW-1:0] pg_q,
  input logic           arr_we,
  input logic           arr_fill,
  input logic [7:0]     arr_wdata,
  input logic [15:0]    erase_len_w
);
  logic [15:0] ecnt;

  always_ff @(posedge clk) begin
    if (rst || (st != ST_ERASE)) ecnt <= '0;
    else                         ecnt <= ecnt + 1'b1;
  end

  AST_BUSY_MATCH: assert property (@(posedge clk) disable iff (rst)
    (busy == (st != ST_IDLE)))
    else $error("busy does not track the active state"); // R6

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!busy |-> !arr_we))
    else $error("array written while idle"); // R8

  AST_ERASE_FILL: assert property (@(posedge clk) disable iff (rst)
    ((arr_we && arr_fill) |-> (arr_wdata == ERASED_BYTE)))
    else $error("erase wrote a byte other than all ones"); // R3

  AST_ERASE_ENTRY: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_ERASE) && ($past(st) != ST_ERASE)) |->
      (($past(st) == ST_IDLE) || ($past(st) == ST_XFER)))
    else $error("erase entered from a wrong state"); // R2

  AST_PROG_ENTRY: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_PROG) && ($past(st) != ST_PROG)) |-> ($past(st) == ST_ERASE))
    else $error("program not preceded by erase"); // R2

  AST_ERASE_MIN_LEN: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_PROG) && ($past(st) == ST_ERASE)) |-> ($past(ecnt) >= erase_len_w - 16'd1))
    else $error("erase phase ended early"); // R3

  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_DONE) |=> ((st == ST_IDLE) && !busy)))
    else $error("done state did not return to idle"); // R6

  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (rst)
    ((busy && $past(busy)) |-> $stable(pg_q)))
    else $error("page selection changed during an operation"); // R7
endmodule

bind pageop_sequencer pageop_seq_chk #(.PAW(PAW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .busy        (busy),
  .st          (st),
  .pg_q        (pg_q),
  .arr_we      (arr_we),
  .arr_fill    (arr_fill),
  .arr_wdata   (arr_wdata),
  .erase_len_w (erase_len_w)
);

// File: tb/pageop_sequencer_test.sv
`timescale 1ns/1ps
module pageop_sequencer_test;
  localparam int NP  = 8;
  localparam int PB  = 264;
  localparam int EL  = 300;
  localparam int PL  = 320;
  localparam int PAW = $clog2(NP);
  localparam int BAW = $clog2(PB);
  localparam int AAW = $clog2(NP * PB);
  localparam logic [7:0] OP_PRG = 8'h82;
  localparam logic [7:0] OP_RWR = 8'h58;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [7:0] opcode = '0;
  logic [PAW-1:0] page = '0;
  logic busy;
  logic hbuf_we = 1'b0;
  logic [BAW-1:0] hbuf_addr = '0;
  logic [7:0] hbuf_wdata = '0;
  logic [BAW-1:0] hbuf_raddr = '0;
  logic [7:0] hbuf_rdata;
  logic [AAW-1:0] arr_raddr = '0;
  logic [7:0] arr_rdata;

  always #10 clk = ~clk;

  pageop_sequencer uut (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .page(page),
    .busy(busy), .hbuf_we(hbuf_we), .hbuf_addr(hbuf_addr),
    .hbuf_wdata(hbuf_wdata), .hbuf_raddr(hbuf_raddr), .hbuf_rdata(hbuf_rdata),
    .arr_raddr(arr_raddr), .arr_rdata(arr_rdata)
  );

  int errors = 0;
  int checks = 0;
  logic [7:0] mdl [NP][PB];
  logic [7:0] bmdl [PB];
  bit written [NP];

  // op task controls
  int probe_at, inject_at, restart_at;
  logic [AAW-1:0] probe_addr;
  logic [7:0] probe_val;
  int busy_len;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [7:0] op);
    return (op == OP_RWR) ? (EL + PL + 1 + PB + 2) : (EL + PL + 1);
  endfunction

  function automatic logic [AAW-1:0] aaddr(input int pg, input int b);
    return AAW'(pg * PB + b);
  endfunction

  task automatic fill_buf(input bit rnd, input logic [7:0] base);
    for (int i = 0; i < PB; i++) begin
      @(negedge clk);
      hbuf_we = 1'b1;
      hbuf_addr = BAW'(i);
      hbuf_wdata = rnd ? 8'($urandom) : 8'(base + 8'(i));
      bmdl[i] = hbuf_wdata;
    end
    @(negedge clk);
    hbuf_we = 1'b0;
  endtask

  task automatic rd_arr(input logic [AAW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    arr_raddr = a;
    @(negedge clk);
    d = arr_rdata;
  endtask

  task automatic rd_buf(input int a, output logic [7:0] d);
    @(negedge clk);
    hbuf_raddr = BAW'(a);
    @(negedge clk);
    d = hbuf_rdata;
  endtask

  // Issues a start and follows the operation until busy falls.
  task automatic run_op(input logic [7:0] op, input int pg);
    int c;
    @(negedge clk);
    start = 1'b1;
    opcode = op;
    page = PAW'(pg);
    @(negedge clk);
    start = 1'b0;
    c = 0;
    while (busy && c < 5000) begin
      c++;
      if (c == probe_at) arr_raddr = probe_addr;
      if (c == probe_at + 1) probe_val = arr_rdata;
      if (c == inject_at) begin
        hbuf_we = 1'b1; hbuf_addr = BAW'(5); hbuf_wdata = ~bmdl[5];
      end
      if (c == inject_at + 1) hbuf_we = 1'b0;
      if (c == restart_at) begin
        start = 1'b1; opcode = OP_RWR; page = PAW'((pg + 1) % NP);
      end
      if (c == restart_at + 1) start = 1'b0;
      @(negedge clk);
    end
    busy_len = c;
    if (op == OP_PRG) begin
      for (int i = 0; i < PB; i++) mdl[pg][i] = bmdl[i];
      written[pg] = 1'b1;
    end
    if (op == OP_RWR) begin
      for (int i = 0; i < PB; i++) bmdl[i] = mdl[pg][i];
    end
    probe_at = -10; inject_at = -10; restart_at = -10;
  endtask

  task automatic check_page(input int pg, input string req, input int nsamp);
    logic [7:0] d;
    int b;
    for (int k = 0; k < nsamp + 2; k++) begin
      b = (k == 0) ? 0 : (k == 1) ? PB - 1 : int'($urandom % PB);
      rd_arr(aaddr(pg, b), d);
      chk(d == mdl[pg][b], req, d, mdl[pg][b]);
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    int pg, other;
    void'($urandom(32'd4242));
    probe_at = -10; inject_at = -10; restart_at = -10;
    for (int p = 0; p < NP; p++) written[p] = 1'b0;

    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R1 busy in reset", busy, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);

    // R8: unknown opcode is ignored
    @(negedge clk);
    start = 1'b1; opcode = 8'h00; page = '0;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b0, "R8 unknown opcode", busy, 0);
    @(negedge clk);
    start = 1'b1; opcode = 8'hD2;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b0, "R8 unknown opcode 2", busy, 0);

    // R2/R4/R6: program every page with an incrementing pattern
    for (int p = 0; p < NP; p++) begin
      fill_buf(1'b0, 8'(p * 37));
      run_op(OP_PRG, p);
      chk(busy_len == exp_len(OP_PRG), "R6 program busy length", busy_len, exp_len(OP_PRG));
      check_page(p, "R4 program data", 2);
    end
    // R8: no memory changed by the ignored requests (page 0 still intact)
    check_page(0, "R8 no memory change", 2);

    // R3: probe mid-erase; byte must read all ones
    fill_buf(1'b1, 8'h00);
    probe_at = 280; probe_addr = aaddr(2, 17);
    run_op(OP_PRG, 2);
    chk(probe_val == 8'hFF, "R3 erased byte", probe_val, 8'hFF);
    chk(busy_len == exp_len(OP_PRG), "R2 program length", busy_len, exp_len(OP_PRG));
    check_page(2, "R4 random program", 4);
    check_page(3, "R4 neighbour untouched", 2);

    // R9: host buffer write during busy has no effect
    fill_buf(1'b1, 8'h00);
    inject_at = 100;
    run_op(OP_PRG, 4);
    rd_arr(aaddr(4, 5), d);
    chk(d == mdl[4][5], "R9 host write ignored", d, mdl[4][5]);

    // R7: a start while busy is ignored
    fill_buf(1'b1, 8'h00);
    restart_at = 50;
    run_op(OP_PRG, 6);
    chk(busy_len == exp_len(OP_PRG), "R7 length unchanged", busy_len, exp_len(OP_PRG));
    check_page(6, "R7 running page", 2);
    check_page(7, "R7 ignored page untouched", 2);
    @(negedge clk);
    chk(busy == 1'b0, "R7 no queued operation", busy, 0);

    // R5: rewrite restores page and loads buffer; also probe erase mid-rewrite
    fill_buf(1'b0, 8'hA5);
    probe_at = PB + 2 + 280; probe_addr = aaddr(1, 200);
    run_op(OP_RWR, 1);
    chk(probe_val == 8'hFF, "R3 erased byte in rewrite", probe_val, 8'hFF);
    chk(busy_len == exp_len(OP_RWR), "R6 rewrite busy length", busy_len, exp_len(OP_RWR));
    check_page(1, "R5 page restored", 4);
    for (int k = 0; k < 6; k++) begin
      int b;
      b = (k == 0) ? 0 : (k == 1) ? PB - 1 : int'($urandom % PB);
      rd_buf(b, d);
      chk(d == mdl[1][b], "R5 buffer loaded R10", d, mdl[1][b]);
    end

    // Random mix of programs and rewrites
    for (int n = 0; n < 8; n++) begin
      pg = int'($urandom % NP);
      other = (pg + 3) % NP;
      if ($urandom % 3 == 0) begin
        run_op(OP_RWR, pg);
        chk(busy_len == exp_len(OP_RWR), "R6 random rewrite length", busy_len, exp_len(OP_RWR));
        check_page(pg, "R5 random rewrite", 3);
      end else begin
        fill_buf(1'b1, 8'h00);
        run_op(OP_PRG, pg);
        chk(busy_len == exp_len(OP_PRG), "R6 random program length", busy_len, exp_len(OP_PRG));
        check_page(pg, "R4 random program", 3);
      end
      if (written[other]) check_page(other, "R4 other page kept", 1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule